// File: doc/BRIEF.md
# I2C Byte FIFO with Watermark Data Requests

This block is the byte queue between a 32-bit host register window and an I2C bit shifter. The host moves one, two or four bytes per access through a single data location, and the shifter moves one byte at a time on the other side. A direction input chooses which side fills the queue. For a write transfer the host pushes and the shifter pops. For a read transfer the shifter pushes and the host pops.

The block keeps a byte count and compares it against a programmable high mark and a programmable low mark. From that comparison it raises a data-request line that tells the host to refill the queue on writes or to drain it on reads. On a read, bytes received after the transfer has ended stay queued until the host removes them. Two sticky flags record host accesses with a byte-enable pattern that is not allowed, and pushes or pops that the queue cannot serve. A rejected access leaves the contents unchanged.

Top module: `i2c_byte_fifo`

## Requirements
- R1: After reset the count is 0, both error flags are 0 and the pointers are at the start of storage.
- R2: `fifo_depth` always reads the DEPTH parameter (8 by default).
- R3: Host byte enables select the access width. 4'b1000 is one byte taken from bits 31:24. 4'b1100 is two bytes, bits 31:24 first and then 23:16. 4'b1111 is four bytes, bits 31:24 first and bits 7:0 last. Pushed bytes queue in that order.
- R4: `host_rdata` holds the oldest queued byte in bits 31:24, the second oldest in bits 23:16, and so on, with zero in every lane beyond the count. `sh_dout` is the oldest byte, or 0 when the queue is empty. A legal host read of n bytes removes n bytes.
- R5: A host access in its active direction with any other byte-enable pattern, including 0, sets `be_err` and leaves the queue unchanged.
- R6: A push larger than the free space, or a pop larger than the count, sets `ovr_err` and leaves the queue unchanged. Both limits use the count at the start of the cycle.
- R7: Strobes of the inactive direction have no effect. When `rx_mode`=0 these are `host_rd` and `sh_push`. When `rx_mode`=1 these are `host_wr` and `sh_pop`.
- R8: The count changes by bytes pushed minus bytes popped, never exceeds DEPTH, and holds when no strobe is active.
- R9: `hi_mark` is 1 exactly when count >= `wm_hi`. `lo_mark` is 1 exactly when count <= `wm_lo`.
- R10: With `rx_mode`=0, `data_req` is 1 exactly when count <= `wm_lo` and `tx_owed` is 1.
- R11: With `rx_mode`=1, `data_req` is 1 when count >= `wm_hi`, or when `xfer_busy` is 0 and the count is nonzero.
- R12: Error flags stay set until `err_clr`. If a new error occurs in the same cycle as `err_clr`, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_mode | input | 1 | 1: shifter fills, host drains; 0: host fills, shifter drains |
| tx_owed | input | 1 | Host still has write bytes to supply |
| xfer_busy | input | 1 | I2C transfer still in progress |
| wm_hi | input | 4 | High mark |
| wm_lo | input | 4 | Low mark |
| host_wr | input | 1 | Host data write strobe |
| host_rd | input | 1 | Host data read strobe |
| host_be | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Oldest bytes, most significant first |
| sh_push | input | 1 | Shifter pushes a received byte |
| sh_pop | input | 1 | Shifter takes a byte to send |
| sh_din | input | 8 | Received byte |
| sh_dout | output | 8 | Next byte to send |
| err_clr | input | 1 | Clear both error flags |
| fifo_count | output | 8 | Bytes queued |
| fifo_depth | output | 8 | Storage depth |
| data_req | output | 1 | Host service request |
| hi_mark | output | 1 | Count at or above high mark |
| lo_mark | output | 1 | Count at or below low mark |
| be_err | output | 1 | Sticky illegal byte-enable flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following every cycle:
- the count bound;
- that the count holds when the queue is idle;
- that a bad byte-enable write freezes the count;
- that popping an empty queue raises the overrun flag;
- that a clear with no new event empties both flags;
- that the write-side request drops when the host owes nothing.

Byte order, lane packing, wraparound of the storage, and the exact request level at each mark setting can only be shown by the bench. It runs directed and random access sequences against its queue model.

// File: rtl/i2c_fifo_pkg.sv
`timescale 1ns/1ps
package i2c_fifo_pkg;
    typedef logic [7:0] byte_t;
    localparam int LANES = 4;
    typedef enum logic [1:0] {XS_NONE, XS_ONE, XS_TWO, XS_FOUR} xsize_e;
endpackage

// File: rtl/i2c_fifo_lane_dec.sv
`timescale 1ns/1ps
module i2c_fifo_lane_dec
    import i2c_fifo_pkg::*;
(
    input  logic [3:0] be,
    output logic [2:0] nbytes,
    output logic       legal
);
    xsize_e size;

    always_comb begin
        unique case (be)
            4'b1000: size = XS_ONE;
            4'b1100: size = XS_TWO;
            4'b1111: size = XS_FOUR;
            default: size = XS_NONE;
        endcase
        unique case (size)
            XS_ONE:  nbytes = 3'd1;
            XS_TWO:  nbytes = 3'd2;
            XS_FOUR: nbytes = 3'd4;
            default: nbytes = 3'd0;
        endcase
        legal = (size != XS_NONE);
    end
endmodule

// File: rtl/i2c_fifo_marks.sv
`timescale 1ns/1ps
module i2c_fifo_marks #(
    parameter int CW = 4
) (
    input  logic [CW-1:0] cnt,
    input  logic [3:0]    wm_hi,
    input  logic [3:0]    wm_lo,
    input  logic          rx_mode,
    input  logic          tx_owed,
    input  logic          xfer_busy,
    output logic          hi_mark,
    output logic          lo_mark,
    output logic          data_req
);
    always_comb begin
        hi_mark = (int'(cnt) >= int'(wm_hi));
        lo_mark = (int'(cnt) <= int'(wm_lo));
        if (rx_mode) begin
            data_req = hi_mark || (!xfer_busy && (cnt != '0));
        end else begin
            data_req = lo_mark && tx_owed;
        end
    end
endmodule

// File: rtl/i2c_byte_fifo.sv
`timescale 1ns/1ps
module i2c_byte_fifo
    import i2c_fifo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic              tx_owed,
    input  logic              xfer_busy,
    input  logic [3:0]        wm_hi,
    input  logic [3:0]        wm_lo,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_be,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              sh_push,
    input  logic              sh_pop,
    input  logic [7:0]        sh_din,
    output logic [7:0]        sh_dout,
    input  logic              err_clr,
    output logic [STAT_W-1:0] fifo_count,
    output logic [STAT_W-1:0] fifo_depth,
    output logic              data_req,
    output logic              hi_mark,
    output logic              lo_mark,
    output logic              be_err,
    output logic              ovr_err
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          be_err;
        logic          ovr;
    } st_t;

    st_t   s_d, s_q;
    byte_t mem_d [DEPTH];
    byte_t mem_q [DEPTH];

    logic [2:0] host_n;
    logic       host_ok;
    logic [2:0] push_n, pop_n;
    byte_t      push_byte [LANES];
    logic       be_ev, ovr_ev;
    int         free_sp;

    i2c_fifo_lane_dec u_dec (
        .be     (host_be),
        .nbytes (host_n),
        .legal  (host_ok)
    );

    always_comb begin
        s_d     = s_q;
        mem_d   = mem_q;
        push_n  = '0;
        pop_n   = '0;
        be_ev   = 1'b0;
        ovr_ev  = 1'b0;
        free_sp = DEPTH - int'(s_q.cnt);
        for (int k = 0; k < LANES; k++) push_byte[k] = '0;

        if (!rx_mode) begin
            if (host_wr) begin
                if (!host_ok) be_ev = 1'b1;
                else if (int'(host_n) > free_sp) ovr_ev = 1'b1;
                else begin
                    push_n = host_n;
                    for (int k = 0; k < LANES; k++) push_byte[k] = host_wdata[31-8*k -: 8];
                end
            end
            if (sh_pop) begin
                if (s_q.cnt == '0) ovr_ev = 1'b1;
                else pop_n = 3'd1;
            end
        end else begin
            if (sh_push) begin
                if (free_sp == 0) ovr_ev = 1'b1;
                else begin
                    push_n       = 3'd1;
                    push_byte[0] = sh_din;
                end
            end
            if (host_rd) begin
                if (!host_ok) be_ev = 1'b1;
                else if (int'(host_n) > int'(s_q.cnt)) ovr_ev = 1'b1;
                else pop_n = host_n;
            end
        end

        for (int k = 0; k < LANES; k++) begin
            if (k < int'(push_n)) mem_d[s_q.wr + PW'(k)] = push_byte[k];
        end
        s_d.wr     = s_q.wr + PW'(push_n);
        s_d.rd     = s_q.rd + PW'(pop_n);
        s_d.cnt    = s_q.cnt + CW'(push_n) - CW'(pop_n);
        s_d.be_err = (s_q.be_err & ~err_clr) | be_ev;
        s_d.ovr    = (s_q.ovr & ~err_clr) | ovr_ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign host_rdata[31-8*g -: 8] =
                (int'(s_q.cnt) > g) ? mem_q[s_q.rd + PW'(g)] : 8'h00;
        end
    endgenerate

    assign sh_dout    = (s_q.cnt != '0) ? mem_q[s_q.rd] : 8'h00;
    assign fifo_count = STAT_W'(s_q.cnt);
    assign fifo_depth = STAT_W'(DEPTH);
    assign be_err     = s_q.be_err;
    assign ovr_err    = s_q.ovr;

    i2c_fifo_marks #(.CW(CW)) u_marks (
        .cnt       (s_q.cnt),
        .wm_hi     (wm_hi),
        .wm_lo     (wm_lo),
        .rx_mode   (rx_mode),
        .tx_owed   (tx_owed),
        .xfer_busy (xfer_busy),
        .hi_mark   (hi_mark),
        .lo_mark   (lo_mark),
        .data_req  (data_req)
    );
endmodule

// File: rtl/i2c_byte_fifo_chk.sv
`timescale 1ns/1ps
module i2c_byte_fifo_chk #(
    parameter int DEPTH  = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_mode,
    input logic              tx_owed,
    input logic              host_wr,
    input logic              host_rd,
    input logic [3:0]        host_be,
    input logic              sh_push,
    input logic              sh_pop,
    input logic              err_clr,
    input logic [STAT_W-1:0] fifo_count,
    input logic              data_req,
    input logic              be_err,
    input logic              ovr_err
);
    logic idle, be_bad;
    assign idle   = !host_wr && !host_rd && !sh_push && !sh_pop;
    assign be_bad = !(host_be == 4'b1000 || host_be == 4'b1100 || host_be == 4'b1111);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= STAT_W'(DEPTH));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> $stable(fifo_count));

    // R5
    bad_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && host_wr && be_bad && !sh_pop) |=> (be_err && $stable(fifo_count)));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && sh_pop && fifo_count == '0 && !host_wr) |=> (ovr_err && fifo_count == '0));

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && idle) |=> (!be_err && !ovr_err));

    // R10
    tx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && !tx_owed) |-> !data_req);
endmodule

bind i2c_byte_fifo i2c_byte_fifo_chk #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_mode    (rx_mode),
    .tx_owed    (tx_owed),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_be    (host_be),
    .sh_push    (sh_push),
    .sh_pop     (sh_pop),
    .err_clr    (err_clr),
    .fifo_count (fifo_count),
    .data_req   (data_req),
    .be_err     (be_err),
    .ovr_err    (ovr_err)
);

// File: tb/i2c_byte_fifo_bench.sv
`timescale 1ns/1ps
module i2c_byte_fifo_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_mode = 1'b0, tx_owed = 1'b0, xfer_busy = 1'b0;
    logic [3:0]  wm_hi = 4'd4, wm_lo = 4'd4;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [3:0]  host_be = 4'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        sh_push = 1'b0, sh_pop = 1'b0;
    logic [7:0]  sh_din = '0, sh_dout;
    logic        err_clr = 1'b0;
    logic [7:0]  fifo_count, fifo_depth;
    logic        data_req, hi_mark, lo_mark, be_err, ovr_err;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] q[$];
    logic m_be = 0, m_ovr = 0;

    always #2.5 clk = ~clk;

    i2c_byte_fifo #(.DEPTH(DEPTH)) u_i2c_byte_fifo (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .tx_owed(tx_owed),
        .xfer_busy(xfer_busy), .wm_hi(wm_hi), .wm_lo(wm_lo),
        .host_wr(host_wr), .host_rd(host_rd), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .sh_push(sh_push), .sh_pop(sh_pop), .sh_din(sh_din), .sh_dout(sh_dout),
        .err_clr(err_clr), .fifo_count(fifo_count), .fifo_depth(fifo_depth),
        .data_req(data_req), .hi_mark(hi_mark), .lo_mark(lo_mark),
        .be_err(be_err), .ovr_err(ovr_err)
    );

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int nb(logic [3:0] be);
        case (be)
            4'b1000: return 1;
            4'b1100: return 2;
            4'b1111: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic model_step();
        int c0 = q.size();
        logic bev = 0, ov = 0;
        if (!rx_mode) begin
            if (host_wr) begin
                int n = nb(host_be);
                if (n == 0) bev = 1;
                else if (n > DEPTH - c0) ov = 1;
                else for (int k = 0; k < n; k++) q.push_back(host_wdata[31-8*k -: 8]);
            end
            if (sh_pop) begin
                if (c0 == 0) ov = 1;
                else void'(q.pop_front());
            end
        end else begin
            if (sh_push) begin
                if (c0 >= DEPTH) ov = 1;
                else q.push_back(sh_din);
            end
            if (host_rd) begin
                int n = nb(host_be);
                if (n == 0) bev = 1;
                else if (n > c0) ov = 1;
                else for (int k = 0; k < n; k++) void'(q.pop_front());
            end
        end
        m_be  = (m_be & ~err_clr) | bev;
        m_ovr = (m_ovr & ~err_clr) | ov;
    endtask

    task automatic compare();
        logic [31:0] er = '0;
        int s = q.size();
        logic ehi, elo, ereq;
        for (int k = 0; k < 4; k++) if (k < s) er[31-8*k -: 8] = q[k];
        ehi = (s >= int'(wm_hi));
        elo = (s <= int'(wm_lo));
        ereq = rx_mode ? (ehi || (!xfer_busy && s != 0)) : (elo && tx_owed);
        check("R8 count", fifo_count, s);
        check("R4 rdata", host_rdata, er);
        check("R4 sh_dout", sh_dout, (s != 0) ? q[0] : 8'h00);
        check("R9 hi_mark", hi_mark, ehi);
        check("R9 lo_mark", lo_mark, elo);
        check(rx_mode ? "R11 data_req" : "R10 data_req", data_req, ereq);
        check("R5 be_err", be_err, m_be);
        check("R6 ovr_err", ovr_err, m_ovr);
        check("R2 depth", fifo_depth, DEPTH);
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        host_wr = 0; host_rd = 0; sh_push = 0; sh_pop = 0; err_clr = 0;
    endtask

    task automatic hw(logic [3:0] be, logic [31:0] d);
        host_wr = 1; host_be = be; host_wdata = d; step();
    endtask

    task automatic hr(logic [3:0] be);
        host_rd = 1; host_be = be; step();
    endtask

    task automatic sp(logic [7:0] d);
        sh_push = 1; sh_din = d; step();
    endtask

    task automatic sq();
        sh_pop = 1; step();
    endtask

    initial begin
        #500us;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=1 exp=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        check("R1 reset count", fifo_count, 0);
        check("R1 reset be_err", be_err, 0);
        check("R1 reset ovr_err", ovr_err, 0);
        check("R2 depth value", fifo_depth, 8);

        // write direction
        tx_owed = 1;
        step();
        check("R10 request when empty", data_req, 1);
        hw(4'b1111, 32'hA1B2C3D4);
        check("R3 four byte order", host_rdata, 32'hA1B2C3D4);
        hw(4'b1000, 32'h55000000);
        hw(4'b1100, 32'h66770000);
        check("R8 count seven", fifo_count, 7);
        check("R10 no request above low", data_req, 0);
        hw(4'b1100, 32'h88990000);
        check("R6 push over free", ovr_err, 1);
        check("R6 count kept", fifo_count, 7);
        err_clr = 1; step();
        check("R12 cleared", ovr_err, 0);
        hw(4'b0110, 32'hFFFFFFFF);
        check("R5 illegal be", be_err, 1);
        check("R5 count kept", fifo_count, 7);
        hw(4'b0000, 32'h0);
        host_rd = 1; host_be = 4'b1111; step();
        check("R7 host read ignored in write mode", fifo_count, 7);
        sp(8'hEE);
        check("R7 shifter push ignored in write mode", fifo_count, 7);
        for (int i = 0; i < 7; i++) sq();
        check("R4 drained", fifo_count, 0);
        sq();
        check("R6 pop empty", ovr_err, 1);
        err_clr = 1; sh_pop = 1; step();
        check("R12 set wins over clear", ovr_err, 1);
        err_clr = 1; step();
        tx_owed = 0; step();
        check("R10 nothing owed", data_req, 0);

        // read direction
        rx_mode = 1; xfer_busy = 1;
        for (int i = 0; i < 3; i++) sp(8'h10 + 8'(i));
        check("R11 below high", data_req, 0);
        sp(8'h13);
        check("R11 at high", data_req, 1);
        sp(8'h14); sp(8'h15);
        hr(4'b1100);
        check("R4 count after two", fifo_count, 4);
        hw(4'b1111, 32'h12345678);
        check("R7 host write ignored in read mode", fifo_count, 4);
        sq();
        check("R7 shifter pop ignored in read mode", fifo_count, 4);
        hr(4'b1000);
        check("R11 under high busy", data_req, 0);
        xfer_busy = 0; step();
        check("R11 trailing bytes", data_req, 1);
        hr(4'b1111);
        check("R6 read over count", ovr_err, 1);
        err_clr = 1; step();
        for (int i = 0; i < 6; i++) sp(8'h40 + 8'(i));
        check("R8 full", fifo_count, 8);
        sp(8'h99);
        check("R6 push full", fifo_count, 8);
        hr(4'b1111); hr(4'b1111);
        check("R11 empty idle", data_req, 0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] bes [5] = '{4'b1000, 4'b1100, 4'b1111, 4'b0011, 4'b1110};
            rx_mode   = ($urandom % 50 == 0) ? ~rx_mode : rx_mode;
            tx_owed   = $urandom % 2;
            xfer_busy = $urandom % 2;
            wm_hi     = $urandom % 10;
            wm_lo     = $urandom % 10;
            host_wr   = ($urandom % 3 == 0);
            host_rd   = ($urandom % 3 == 0);
            host_be   = bes[$urandom % 5];
            host_wdata = $urandom;
            sh_push   = $urandom % 2;
            sh_pop    = $urandom % 2;
            sh_din    = $urandom;
            err_clr   = ($urandom % 8 == 0);
            step();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule